// File: doc/BRIEF.md
# Spread-Spectrum Chip-to-Bit Correlator

This block turns a direct-sequence spread-spectrum chip stream back into data bits. Each data bit is carried by a run of chips that is either a copy of a pseudo-noise spreading code or its bitwise inverse. The code is 64 chips long, or 32 chips when the short-code mode is selected. For every chip accepted in a bit period, the block compares the chip with the code bit at the same position and counts the matches. When the period ends it decides the bit.

The decision uses two separate limits. A match count at or above the high limit gives a logic 1. A count at or below the low limit gives a logic 0. A count that falls between the two limits is reported as an erasure, so it is never forced to a value. Each limit arrives as an 8-bit value whose top bit is reserved and ignored.

The surrounding receiver marks the first chip of every bit with an alignment pulse. It also supplies the code, the length select and the two limits. The limits and the length are captured at the alignment pulse, so a change during a period applies only from the next bit on. Before reset releases, the captured limits default to 8 (low) and 56 (high). With these defaults a 64-chip bit can hold up to eight wrong chips and still decode as either value.

Top module: `dsss_bit_correlator`

## Requirements
- R1: While reset is asserted and right after it is released, bitValid, bitInvalid and bitOut are 0 and matchCount is 0.
- R2: A 64-chip period in which every chip equals pnCode[i] gives matchCount 64, bitValid 1 and bitOut 1.
- R3: A 64-chip period in which every chip is the inverse of pnCode[i] gives matchCount 0, bitValid 1 and bitOut 0.
- R4: With lenShort at 1, a period ends after 32 accepted chips, which are compared with pnCode[31:0]. With lenShort at 0, a period ends after 64 chips compared with pnCode[63:0].
- R5: A final count greater than or equal to thrHigh[6:0] decides 1. Otherwise, a count less than or equal to thrLow[6:0] decides 0. Both limits are inclusive.
- R6: A final count strictly above thrLow[6:0] and strictly below thrHigh[6:0] raises bitInvalid for one cycle, and bitValid stays 0.
- R7: When thrLow[6:0] is greater than or equal to thrHigh[6:0], a count that meets both limits decides 1.
- R8: Bit 7 of thrLow and bit 7 of thrHigh have no effect on any decision.
- R9: The decision (bitValid or bitInvalid) appears in the clock cycle right after the edge that takes the last chip, and lasts exactly one cycle. Cycles with chipValid low are not counted, and they do not advance the chip position.
- R10: thrLow, thrHigh and lenShort are sampled only in the cycle that carries bitSync. A change during a period applies from the next period on.
- R11: bitSync clears the count and restarts at chip position 0. The chip presented in the bitSync cycle is chip 0. A period cut short by a new bitSync yields no decision. Chips that arrive before the first bitSync, or after a period has ended, are ignored: matchCount keeps its value and no decision is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipIn | input | 1 | Received chip value |
| chipValid | input | 1 | chipIn carries a chip this cycle |
| bitSync | input | 1 | First chip of a bit period (alignment pulse) |
| pnCode | input | 64 | Spreading code; bit i is compared with chip i |
| lenShort | input | 1 | 1 selects 32 chips per bit, 0 selects 64 |
| thrLow | input | 8 | Low limit in bits 6:0; bit 7 is reserved |
| thrHigh | input | 8 | High limit in bits 6:0; bit 7 is reserved |
| bitOut | output | 1 | Decided bit value, meaningful when bitValid is 1 |
| bitValid | output | 1 | One-cycle pulse: a 0 or a 1 was decided |
| bitInvalid | output | 1 | One-cycle pulse: the count fell between the limits |
| matchCount | output | 7 | Running count of matching chips in the current or last period |

## Verification
The assertions expect bitSync and the last chip of a period never to fall in the same cycle. That holds because a period is at least 32 chips long. The assertions also expect the reserved bits of the limits to be ignored. The stimulus always starts a period with bitSync on the cycle that carries chip 0. It changes limits or length in the middle of a period only to show that the change waits for the next period. Periods that are cut short, chip gaps, and stray chips outside any period are driven on purpose, so that the counting and timing assertions are exercised against those inputs.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int MAX_CHIPS   = 64;
  localparam int SHORT_CHIPS = 32;
  localparam int CNT_W       = $clog2(MAX_CHIPS + 1);
  localparam int IDX_W       = $clog2(MAX_CHIPS);
  localparam int REG_W       = 8;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             clear;  // new period starts this cycle
    logic             take;   // a chip is counted this cycle
    logic             last;   // that chip closes the period
    logic [IDX_W-1:0] idx;    // code position of that chip
  } corrStrobe_t;
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipValid,
  input  logic        bitSync,
  input  logic        lenShort,
  output corrStrobe_t strobe
);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(MAX_CHIPS - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_CHIPS - 1);

  logic             active;
  logic             lenLat;
  logic [IDX_W-1:0] idx;
  logic             effShort;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] curIdx;
  logic             take;
  logic             last;

  // The length seen in the bitSync cycle governs the whole period.
  assign effShort = bitSync ? lenShort : lenLat;
  assign lastIdx  = effShort ? LAST_SHORT : LAST_LONG;
  assign curIdx   = bitSync ? '0 : idx;
  assign take     = chipValid & (bitSync | active);
  assign last     = take & (curIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      lenLat <= 1'b0;
      idx    <= '0;
    end else begin
      if (bitSync) lenLat <= lenShort;
      if (bitSync || take) active <= ~last;
      if (take) idx <= curIdx + IDX_W'(1);
      else if (bitSync) idx <= '0;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.clear = bitSync;
    strobe.take  = take;
    strobe.last  = last;
    strobe.idx   = curIdx;
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (idx <= (lenLat ? LAST_SHORT : LAST_LONG))); // R4
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !bitSync) |-> !strobe.take); // R11
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !bitSync |=> $stable(lenLat)); // R10
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter logic [REG_W-1:0] THR_LOW_DEF  = 8'd8,
  parameter logic [REG_W-1:0] THR_HIGH_DEF = 8'd56
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipIn,
  input  logic [MAX_CHIPS-1:0] pnCode,
  input  logic [REG_W-1:0]     thrLowReg,
  input  logic [REG_W-1:0]     thrHighReg,
  input  corrStrobe_t          strobe,
  output logic                 bitOut,
  output logic                 bitValid,
  output logic                 bitInvalid,
  output logic [CNT_W-1:0]     matchCount
);
  localparam logic [REG_W-1:0] RSV_MASK = {1'b0, {(REG_W-1){1'b1}}};

  logic [REG_W-1:0] thrLowLat;
  logic [REG_W-1:0] thrHighLat;
  logic             chipMatch;
  logic [CNT_W-1:0] baseCount;
  logic [CNT_W-1:0] nextCount;
  logic [REG_W-1:0] cmpCount;
  logic             meetsHigh;
  logic             meetsLow;

  assign chipMatch = (chipIn == pnCode[strobe.idx]);
  assign baseCount = strobe.clear ? '0 : matchCount;
  assign nextCount = baseCount + CNT_W'(strobe.take & chipMatch);
  assign cmpCount  = REG_W'(nextCount);
  // The high limit is tested first, so a 1 wins when the limits overlap.
  assign meetsHigh = (cmpCount >= thrHighLat);
  assign meetsLow  = (cmpCount <= thrLowLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrLowLat  <= THR_LOW_DEF & RSV_MASK;
      thrHighLat <= THR_HIGH_DEF & RSV_MASK;
      matchCount <= '0;
      bitOut     <= 1'b0;
      bitValid   <= 1'b0;
      bitInvalid <= 1'b0;
    end else begin
      if (strobe.clear) begin
        thrLowLat  <= thrLowReg & RSV_MASK;
        thrHighLat <= thrHighReg & RSV_MASK;
      end
      if (strobe.clear || strobe.take) matchCount <= nextCount;
      bitOut     <= strobe.last & meetsHigh;
      bitValid   <= strobe.last & (meetsHigh | meetsLow);
      bitInvalid <= strobe.last & ~meetsHigh & ~meetsLow;
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && bitInvalid)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    matchCount <= CNT_W'(MAX_CHIPS)); // R2
  AST_INVALID_BAND: assert property (@(posedge clk) disable iff (!rstN)
    bitInvalid |-> (REG_W'(matchCount) > thrLowLat && REG_W'(matchCount) < thrHighLat)); // R6
  AST_ONE_MEETS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitOut) |-> (REG_W'(matchCount) >= thrHighLat)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && !strobe.take) |=> (matchCount == '0)); // R11
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> ($stable(thrHighLat) && $stable(thrLowLat))); // R10
endmodule

// File: rtl/dsss_bit_correlator.sv
module dsss_bit_correlator
  import corr_pkg::*;
#(
  parameter logic [REG_W-1:0] THR_LOW_DEF  = 8'd8,
  parameter logic [REG_W-1:0] THR_HIGH_DEF = 8'd56
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipIn,
  input  logic                 chipValid,
  input  logic                 bitSync,
  input  logic [MAX_CHIPS-1:0] pnCode,
  input  logic                 lenShort,
  input  logic [REG_W-1:0]     thrLow,
  input  logic [REG_W-1:0]     thrHigh,
  output logic                 bitOut,
  output logic                 bitValid,
  output logic                 bitInvalid,
  output logic [CNT_W-1:0]     matchCount
);
  corrStrobe_t strobe;

  corr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .chipValid (chipValid),
    .bitSync   (bitSync),
    .lenShort  (lenShort),
    .strobe    (strobe)
  );

  corr_datapath #(
    .THR_LOW_DEF  (THR_LOW_DEF),
    .THR_HIGH_DEF (THR_HIGH_DEF)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .chipIn     (chipIn),
    .pnCode     (pnCode),
    .thrLowReg  (thrLow),
    .thrHighReg (thrHigh),
    .strobe     (strobe),
    .bitOut     (bitOut),
    .bitValid   (bitValid),
    .bitInvalid (bitInvalid),
    .matchCount (matchCount)
  );

  AST_DECIDE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> (bitValid ^ bitInvalid)); // R9
  AST_DECIDE_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid || bitInvalid) |-> $past(strobe.last)); // R9
  AST_BIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    bitOut |-> bitValid); // R5
endmodule

// File: tb/dsss_bit_correlator_tb.sv
module dsss_bit_correlator_tb_top;
  localparam logic [63:0] PN = 64'hA5C3_96F0_1E2D_7B48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipIn = 1'b0;
  logic        chipValid = 1'b0;
  logic        bitSync = 1'b0;
  logic [63:0] pnCode = PN;
  logic        lenShort = 1'b0;
  logic [7:0]  thrLow = 8'd8;
  logic [7:0]  thrHigh = 8'd56;
  logic        bitOut, bitValid, bitInvalid;
  logic [6:0]  matchCount;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic       obsBit, obsValid, obsInv, obsEarly, obsAfter;
  logic [6:0] obsCnt;

  always #2.5 clk = ~clk;

  dsss_bit_correlator dut_i (
    .clk(clk), .rstN(rstN), .chipIn(chipIn), .chipValid(chipValid),
    .bitSync(bitSync), .pnCode(pnCode), .lenShort(lenShort),
    .thrLow(thrLow), .thrHigh(thrHigh), .bitOut(bitOut),
    .bitValid(bitValid), .bitInvalid(bitInvalid), .matchCount(matchCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkChips(input bit val, input int errs);
    logic [63:0] v = val ? PN : ~PN;
    for (int i = 0; i < errs; i++) v[i] = ~v[i];
    return v;
  endfunction

  function automatic int countMatch(input logic [63:0] chips, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (chips[i] == PN[i]) c++;
    return c;
  endfunction

  task automatic setCfg(input logic [7:0] lo, input logic [7:0] hi, input logic sh);
    thrLow = lo; thrHigh = hi; lenShort = sh;
  endtask

  task automatic runPeriod(input logic [63:0] chips, input int n, input bit gaps,
                           input int changeAt, input logic [7:0] nLow,
                           input logic [7:0] nHigh, input logic nLen);
    obsEarly = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0 && (bitValid || bitInvalid)) obsEarly = 1'b1;
      if (gaps && i > 0) begin
        chipValid = 1'b0; bitSync = 1'b0;
        @(negedge clk);
        if (bitValid || bitInvalid) obsEarly = 1'b1;
      end
      if (i == changeAt) begin thrLow = nLow; thrHigh = nHigh; lenShort = nLen; end
      bitSync = (i == 0); chipValid = 1'b1; chipIn = chips[i];
    end
    @(negedge clk);
    chipValid = 1'b0; bitSync = 1'b0;
    obsBit = bitOut; obsValid = bitValid; obsInv = bitInvalid; obsCnt = matchCount;
    @(negedge clk);
    obsAfter = bitValid || bitInvalid;
  endtask

  // Expected decision from the limit rules, reserved bit masked off.
  task automatic checkPeriod(input string req, input int expCnt,
                             input logic [7:0] lo, input logic [7:0] hi);
    bit h = expCnt >= int'(hi[6:0]);
    bit l = expCnt <= int'(lo[6:0]);
    bit v = h || l;
    check(obsCnt == 7'(expCnt), req, "matchCount", obsCnt, expCnt);
    check(obsValid == v, req, "bitValid", obsValid, v);
    check(obsInv == !v, req, "bitInvalid", obsInv, !v);
    if (v) check(obsBit == h, req, "bitOut", obsBit, h);
    check(!obsEarly, req, "no early decision", obsEarly, 0);
    check(!obsAfter, req, "one-cycle pulse (R9)", obsAfter, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!bitValid && !bitInvalid && !bitOut, "R1", "flags in reset",
          {bitValid, bitInvalid, bitOut}, 0);
    check(matchCount == 0, "R1", "count in reset", matchCount, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(!bitValid && !bitInvalid && matchCount == 0, "R1", "after release",
          matchCount, 0);
  endtask

  task automatic testStrayBeforeSync();
    bit seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chipValid = 1'b1; chipIn = PN[i];
      if (bitValid || bitInvalid) seen = 1'b1;
    end
    @(negedge clk); chipValid = 1'b0;
    check(matchCount == 0, "R11", "stray chips before sync", matchCount, 0);
    check(!seen && !bitValid && !bitInvalid, "R11", "no decision before sync", seen, 0);
  endtask

  task automatic testPerfectOne();
    logic [63:0] c = mkChips(1'b1, 0);
    setCfg(8'd8, 8'd56, 1'b0);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R2", 64, 8'd8, 8'd56);
  endtask

  task automatic testPerfectZero();
    logic [63:0] c = mkChips(1'b0, 0);
    setCfg(8'd8, 8'd56, 1'b0);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R3", 0, 8'd8, 8'd56);
  endtask

  task automatic testShort();
    logic [63:0] c = mkChips(1'b1, 0);
    setCfg(8'd4, 8'd28, 1'b1);
    runPeriod(c, 32, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R4", 32, 8'd4, 8'd28);
    c = mkChips(1'b0, 3);
    setCfg(8'd4, 8'd28, 1'b1);
    runPeriod(c, 32, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R4", countMatch(c, 32), 8'd4, 8'd28);
  endtask

  task automatic testLimits();
    logic [63:0] c;
    setCfg(8'd8, 8'd56, 1'b0);
    c = mkChips(1'b1, 8);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R5", 56, 8'd8, 8'd56);
    c = mkChips(1'b0, 8);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R5", 8, 8'd8, 8'd56);
    c = mkChips(1'b1, 9);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R6", 55, 8'd8, 8'd56);
    c = mkChips(1'b0, 9);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R6", 9, 8'd8, 8'd56);
  endtask

  task automatic testOverlap();
    logic [63:0] c;
    setCfg(8'd40, 8'd30, 1'b0);
    c = mkChips(1'b1, 29);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R7", 35, 8'd40, 8'd30);
    c = mkChips(1'b0, 20);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R7", 20, 8'd40, 8'd30);
  endtask

  task automatic testReservedBit();
    logic [63:0] c;
    setCfg(8'h88, 8'hB8, 1'b0);
    c = mkChips(1'b1, 8);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R8", 56, 8'h88, 8'hB8);
    c = mkChips(1'b0, 8);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R8", 8, 8'h88, 8'hB8);
  endtask

  task automatic testGaps();
    logic [63:0] c = mkChips(1'b1, 5);
    setCfg(8'd8, 8'd56, 1'b0);
    runPeriod(c, 64, 1'b1, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R9", 59, 8'd8, 8'd56);
  endtask

  task automatic testMidChange();
    logic [63:0] c = mkChips(1'b1, 4);
    setCfg(8'd8, 8'd56, 1'b0);
    runPeriod(c, 64, 1'b0, 10, 8'd8, 8'd64, 1'b0);
    checkPeriod("R10", 60, 8'd8, 8'd56);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R10", 60, 8'd8, 8'd64);
    c = mkChips(1'b1, 0);
    setCfg(8'd8, 8'd56, 1'b0);
    runPeriod(c, 64, 1'b0, 5, 8'd8, 8'd56, 1'b1);
    checkPeriod("R10", 64, 8'd8, 8'd56);
  endtask

  task automatic testAbortAndTail();
    logic [63:0] c = mkChips(1'b0, 0);
    logic [6:0]  held;
    bit seen = 1'b0;
    setCfg(8'd8, 8'd56, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bitSync = (i == 0); chipValid = 1'b1; chipIn = c[i];
    end
    c = mkChips(1'b1, 0);
    runPeriod(c, 64, 1'b0, -1, 8'd0, 8'd0, 1'b0);
    checkPeriod("R11", 64, 8'd8, 8'd56);
    held = matchCount;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chipValid = 1'b1; chipIn = PN[i];
      if (bitValid || bitInvalid) seen = 1'b1;
    end
    @(negedge clk); chipValid = 1'b0;
    if (bitValid || bitInvalid) seen = 1'b1;
    check(matchCount == held, "R11", "chips after period end", matchCount, held);
    check(!seen, "R11", "no decision after period end", seen, 0);
  endtask

  initial begin
    testReset();
    testStrayBeforeSync();
    testPerfectOne();
    testPerfectZero();
    testShort();
    testLimits();
    testOverlap();
    testReservedBit();
    testGaps();
    testMidChange();
    testAbortAndTail();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule